// File: doc/BRIEF.md
# Instruction Fetch Stall Sequencer

This block steps a single-issue processor front end one instruction at a time. While it is running it puts out a word-aligned fetch address each cycle, and the instruction cache answers hit or miss in the same cycle. On a hit the fetched instruction executes in that cycle. The processor then retires it and updates its program counter pair, or raises a trap.

An instruction-cache miss parks the sequencer in a stall until the cache signals completion. It then passes through one extra state, in which the fetched instruction executes without a second fetch. A data-cache miss is reported by the instruction that caused it. The instruction still retires, and the sequencer waits in a data stall until completion, then goes straight back to running. Both kinds of stall are measured in cycles and summed into saturating counters, one per cache.

A small register file sits alongside, and its entry zero always reads as zero. A completion pulse that arrives while no miss is outstanding sets a sticky error flag.

Top module: `fetch_stall_seq`

## Requirements
- R1: `fetch_addr` equals the program counter with bits [1:0] forced to zero, and `fetch_req` is high only in the running state.
- R2: In the running state, a high `ic_miss` holds `exec_en` low and moves the state to instruction stall (code 2) on the next edge.
- R3: A `miss_done` pulse in instruction stall adds to `istall_cnt` the number of cycles spent in that stall, counting the completion cycle, and moves the state to miss-complete (code 3).
- R4: In miss-complete, `fetch_req` is low and `exec_en` is high. The state then leaves to running, data stall or idle, never back to a stall on the instruction side.
- R5: A `miss_done` pulse in data stall (code 4) adds the stall's cycles, completion cycle included, to `dstall_cnt` and returns the state to running (code 0). A `dc_miss` on an executing, non-faulting instruction enters data stall.
- R6: A `miss_done` pulse in running, idle or miss-complete sets `err_flag`, which stays high until reset.
- R7: An executing instruction without fault loads `pc` from `npc` and adds 4 to `npc`.
- R8: An executing instruction with `ex_fault` high drives `trap_req` high and leaves `pc` and `npc` unchanged. The state stays running.
- R9: `rf_rdata` is zero whenever `rf_raddr` is 0, whatever was written there. The other entries return the last value written by an executing instruction.
- R10: `ex_halt` on an executing, non-faulting instruction without `dc_miss` enters idle (code 1). In idle, `ic_miss` is ignored, and `wake` returns the sequencer to running.
- R11: Synchronous active-high `rst` gives state running, `pc` = `reset_vec`, `npc` = `reset_vec`+4, both stall counters zero and `err_flag` low.
- R12: The stall counters saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_vec | input | ADDR_W | Program counter value loaded at reset |
| ic_miss | input | 1 | Instruction cache miss for this cycle's fetch |
| dc_miss | input | 1 | Executing instruction missed the data cache |
| ex_fault | input | 1 | Executing instruction faulted |
| ex_halt | input | 1 | Executing instruction requests idle |
| wake | input | 1 | Leave idle |
| miss_done | input | 1 | Single-cycle miss completion pulse |
| rf_we | input | 1 | Register write from the executing instruction |
| rf_waddr | input | RA_W | Register write index |
| rf_wdata | input | DATA_W | Register write data |
| rf_raddr | input | RA_W | Register read index |
| rf_rdata | output | DATA_W | Register read data |
| fetch_req | output | 1 | Fetch issued this cycle |
| fetch_addr | output | ADDR_W | Word-aligned fetch address |
| exec_en | output | 1 | An instruction executes this cycle |
| trap_req | output | 1 | Fault trap request |
| pc | output | ADDR_W | Program counter |
| npc | output | ADDR_W | Next program counter |
| state | output | 3 | 0 run, 1 idle, 2 instruction stall, 3 miss-complete, 4 data stall |
| istall_cnt | output | CNT_W | Instruction stall cycles |
| dstall_cnt | output | CNT_W | Data stall cycles |
| err_flag | output | 1 | Sticky unexpected-completion flag |

## Verification
The assertions watch the state transitions on every cycle. They cover entry into instruction stall, the step from stall to miss-complete and on to a non-stall state, the return from data stall, and the program counter update or hold. They also check the sticky error flag and that neither counter ever goes down. The exact amount each stall adds, the alignment of the fetch address, the zero register and the saturation at all ones can only be seen in the bench scenarios. These compare outputs against hand-computed values after stalls of known length.

// File: rtl/fetch_stall_seq.sv
module fetch_stall_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec,
  input  logic              ic_miss,
  input  logic              dc_miss,
  input  logic              ex_fault,
  input  logic              ex_halt,
  input  logic              wake,
  input  logic              miss_done,
  input  logic              rf_we,
  input  logic [RA_W-1:0]   rf_waddr,
  input  logic [DATA_W-1:0] rf_wdata,
  input  logic [RA_W-1:0]   rf_raddr,
  output logic [DATA_W-1:0] rf_rdata,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              exec_en,
  output logic              trap_req,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic [2:0]        state,
  output logic [CNT_W-1:0]  istall_cnt,
  output logic [CNT_W-1:0]  dstall_cnt,
  output logic              err_flag
);

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_ISTALL = 3'd2,
    ST_ICOMP  = 3'd3,
    ST_DSTALL = 3'd4
  } seq_st_t;

  seq_st_t st_q, st_d, after_exec;
  logic [CNT_W-1:0] el_q, el_inc;
  logic [DATA_W-1:0] regs [NREG];
  logic in_run, in_idle, in_istall, in_icomp, in_dstall, in_stall, retire;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  assign in_run    = (st_q == ST_RUN);
  assign in_idle   = (st_q == ST_IDLE);
  assign in_istall = (st_q == ST_ISTALL);
  assign in_icomp  = (st_q == ST_ICOMP);
  assign in_dstall = (st_q == ST_DSTALL);
  assign in_stall  = in_istall | in_dstall;

  assign state      = st_q;
  assign fetch_req  = in_run;
  assign fetch_addr = {pc[ADDR_W-1:2], 2'b00};
  assign exec_en    = (in_run && !ic_miss) || in_icomp;
  assign trap_req   = exec_en && ex_fault;
  assign retire     = exec_en && !ex_fault;
  assign el_inc     = sat_add(el_q, {{(CNT_W-1){1'b0}}, 1'b1});

  always_comb begin
    if (ex_fault)     after_exec = ST_RUN;
    else if (dc_miss) after_exec = ST_DSTALL;
    else if (ex_halt) after_exec = ST_IDLE;
    else              after_exec = ST_RUN;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:    st_d = ic_miss ? ST_ISTALL : after_exec;
      ST_ICOMP:  st_d = after_exec;
      ST_IDLE:   st_d = wake ? ST_RUN : ST_IDLE;
      ST_ISTALL: st_d = miss_done ? ST_ICOMP : ST_ISTALL;
      ST_DSTALL: st_d = miss_done ? ST_RUN : ST_DSTALL;
      default:   st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RUN;
      pc         <= reset_vec;
      npc        <= reset_vec + ADDR_W'(4);
      istall_cnt <= '0;
      dstall_cnt <= '0;
      el_q       <= '0;
      err_flag   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (retire) begin
        pc  <= npc;
        npc <= npc + ADDR_W'(4);
      end
      if (in_stall && !miss_done) el_q <= el_inc;
      else                        el_q <= '0;
      if (in_istall && miss_done) istall_cnt <= sat_add(istall_cnt, el_inc);
      if (in_dstall && miss_done) dstall_cnt <= sat_add(dstall_cnt, el_inc);
      if (miss_done && !in_stall) err_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (exec_en && rf_we && rf_waddr != '0) regs[rf_waddr] <= rf_wdata;
  end

  assign rf_rdata = (rf_raddr == '0) ? '0 : regs[rf_raddr];

  AST_IMISS_ENTER: assert property (@(posedge clk) disable iff (rst)
    (in_run && ic_miss) |=> (state == 3'd2)); // R2
  AST_ISTALL_DONE: assert property (@(posedge clk) disable iff (rst)
    (in_istall && miss_done) |=> (state == 3'd3)); // R3
  AST_ICOMP_LEAVE: assert property (@(posedge clk) disable iff (rst)
    in_icomp |=> (state != 3'd2 && state != 3'd3)); // R4
  AST_DSTALL_DONE: assert property (@(posedge clk) disable iff (rst)
    (in_dstall && miss_done) |=> (state == 3'd0)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag || (miss_done && !in_stall)) |=> err_flag); // R6
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !ex_fault) |=> (pc == $past(npc) && npc == $past(npc) + ADDR_W'(4))); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (exec_en && ex_fault) |=> ($stable(pc) && $stable(npc) && state == 3'd0)); // R8
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !wake) |=> (state == 3'd1)); // R10
  AST_NO_WRAP_I: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (istall_cnt >= $past(istall_cnt))); // R12
  AST_NO_WRAP_D: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dstall_cnt >= $past(dstall_cnt))); // R12

endmodule

// File: tb/fetch_stall_seq_tb_top.sv
module fetch_stall_seq_tb_top;
  localparam int CW = 4;
  logic clk = 0, rst = 1;
  logic [31:0] reset_vec = 32'h0000_1006;
  logic ic_miss = 0, dc_miss = 0, ex_fault = 0, ex_halt = 0, wake = 0, miss_done = 0;
  logic rf_we = 0;
  logic [4:0] rf_waddr = 0, rf_raddr = 0;
  logic [31:0] rf_wdata = 0, rf_rdata;
  logic fetch_req, exec_en, trap_req, err_flag;
  logic [31:0] fetch_addr, pc, npc;
  logic [2:0] state;
  logic [CW-1:0] istall_cnt, dstall_cnt;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] e_pc, e_npc;
  int e_icnt, e_dcnt;

  fetch_stall_seq #(.ADDR_W(32), .CNT_W(CW), .DATA_W(32), .NREG(32)) dut_i (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .ic_miss(ic_miss), .dc_miss(dc_miss),
    .ex_fault(ex_fault), .ex_halt(ex_halt), .wake(wake), .miss_done(miss_done),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .fetch_req(fetch_req), .fetch_addr(fetch_addr), .exec_en(exec_en),
    .trap_req(trap_req), .pc(pc), .npc(npc), .state(state), .istall_cnt(istall_cnt),
    .dstall_cnt(dstall_cnt), .err_flag(err_flag));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
  endfunction

  task automatic retire_model();
    e_pc = e_npc;
    e_npc = e_npc + 4;
  endtask

  task automatic t_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    e_pc = 32'h1006; e_npc = 32'h100A; e_icnt = 0; e_dcnt = 0;
    chk("R11 state", 32'(state), 0);
    chk("R11 pc", pc, e_pc);
    chk("R11 npc", npc, e_npc);
    chk("R11 counters", {istall_cnt, dstall_cnt}, 0);
    chk("R11 err", 32'(err_flag), 0);
    chk("R1 align", fetch_addr, 32'h1004);
    chk("R1 req", 32'(fetch_req), 1);
  endtask

  task automatic t_step();
    #1 chk("R7 exec_en", 32'(exec_en), 1);
    @(negedge clk); retire_model();
    chk("R7 pc", pc, e_pc);
    chk("R7 npc", npc, e_npc);
    chk("R1 align after step", fetch_addr, {e_pc[31:2], 2'b00});
  endtask

  task automatic t_fault();
    ex_fault = 1;
    #1 chk("R8 trap", 32'(trap_req), 1);
    @(negedge clk); ex_fault = 0;
    chk("R8 pc hold", pc, e_pc);
    chk("R8 npc hold", npc, e_npc);
    chk("R8 state", 32'(state), 0);
  endtask

  task automatic t_imiss(input int k);
    ic_miss = 1;
    #1 chk("R2 no exec", 32'(exec_en), 0);
    @(negedge clk); ic_miss = 0;
    chk("R2 state", 32'(state), 2);
    chk("R1 no fetch in stall", 32'(fetch_req), 0);
    chk("R2 pc held", pc, e_pc);
    for (int i = 1; i <= k; i++) begin
      if (i == k) miss_done = 1;
      @(negedge clk); miss_done = 0;
    end
    e_icnt = sat(e_icnt + k);
    chk("R3 state", 32'(state), 3);
    chk("R3 R12 istall_cnt", 32'(istall_cnt), 32'(e_icnt));
    chk("R3 err untouched", 32'(err_flag), 0);
    #1 chk("R4 no fetch", 32'(fetch_req), 0);
    chk("R4 exec", 32'(exec_en), 1);
    @(negedge clk); retire_model();
    chk("R4 back to run", 32'(state), 0);
    chk("R4 pc", pc, e_pc);
  endtask

  task automatic t_dmiss(input int k);
    dc_miss = 1;
    @(negedge clk); dc_miss = 0; retire_model();
    chk("R5 state", 32'(state), 4);
    chk("R5 pc retired", pc, e_pc);
    for (int i = 1; i <= k; i++) begin
      if (i == k) miss_done = 1;
      @(negedge clk); miss_done = 0;
    end
    e_dcnt = sat(e_dcnt + k);
    chk("R5 run", 32'(state), 0);
    chk("R5 dstall_cnt", 32'(dstall_cnt), 32'(e_dcnt));
    chk("R5 istall untouched", 32'(istall_cnt), 32'(e_icnt));
  endtask

  task automatic t_zero();
    rf_we = 1; rf_waddr = 0; rf_wdata = 32'hA5A5_A5A5;
    @(negedge clk); retire_model();
    rf_waddr = 5; rf_wdata = 32'h5A5A_0001;
    @(negedge clk); retire_model();
    rf_we = 0; rf_raddr = 0;
    #1 chk("R9 zero reg", rf_rdata, 0);
    rf_raddr = 5;
    #1 chk("R9 reg5", rf_rdata, 32'h5A5A_0001);
  endtask

  task automatic t_idle();
    ex_halt = 1;
    @(negedge clk); ex_halt = 0; retire_model();
    chk("R10 idle", 32'(state), 1);
    chk("R10 no fetch", 32'(fetch_req), 0);
    ic_miss = 1;
    @(negedge clk); ic_miss = 0;
    chk("R10 ic_miss ignored", 32'(state), 1);
    chk("R10 pc idle", pc, e_pc);
    wake = 1;
    @(negedge clk); wake = 0;
    chk("R10 wake", 32'(state), 0);
  endtask

  task automatic t_err();
    chk("R6 clear before", 32'(err_flag), 0);
    miss_done = 1;
    @(negedge clk); miss_done = 0; retire_model();
    chk("R6 err set", 32'(err_flag), 1);
    @(negedge clk); retire_model();
    chk("R6 err sticky", 32'(err_flag), 1);
  endtask

  initial begin
    t_reset();
    t_step();
    t_fault();
    t_imiss(3);
    t_dmiss(4);
    t_zero();
    t_idle();
    t_imiss(14);
    t_dmiss(13);
    t_step();
    t_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule